// File: doc/BRIEF.md
# Multicast Packet Split-Recombine Unit

This unit sits between route computation and the crossbar of a mesh router with seven ports (local, four planar, two vertical). It takes one multicast packet at a time: a data word, up to `NUM_DEST` destination addresses, and for each destination a mask of the output ports that route computation found usable. Each destination is settled to a single port. Destinations that settle on the same port are then merged, so one copy of the data goes out with only the addresses that share that port.

When a destination may leave through either a horizontal (east/west) or a vertical-plane (north/south) port, a one-bit alternating flag makes the choice. This spreads traffic over the two planar axes. The resulting sub-packets are handed to the crossbar one per cycle under a valid/ready handshake, each tagged with a one-hot output port. The unit takes no new packet until the last sub-packet of the current one has been taken.

Top module: `mcr_split_recombine`

## Requirements
- R1: `req_ready` is high exactly when the unit holds no pending sub-packet. A request presented while busy is not taken and does not disturb the sub-packets in progress.
- R2: When `req_valid` and `req_ready` are both high at a clock edge, the packet is captured, and its first sub-packet appears on `sp_valid` in the following cycle, carrying the captured data word.
- R3: Candidate mask encoding is bit 0 local, bit 1 east, bit 2 west, bit 3 north, bit 4 south, bit 5 up, bit 6 down. A zero mask marks an absent destination. A mask that is not ambiguous (see R4) settles on its lowest set bit.
- R4: A mask that holds at least one east/west bit and at least one north/south bit is ambiguous. It settles on its lowest east/west bit when the flag is 0, and on its lowest north/south bit when the flag is 1.
- R5: The flag is 0 after reset and inverts once per ambiguous destination. Within one packet, destinations are settled in index order, so each ambiguous destination sees the flag as left by the ones before it.
- R6: All present destinations settled on one port form exactly one sub-packet. `sp_dmask` bit i is set for each member i. Address lane i holds the member's address, and lanes of non-members are zero.
- R7: Sub-packets leave in port order local, east, west, north, south, up, down, with empty ports skipped. `sp_port` is one-hot using the bit positions of R3.
- R8: While `sp_valid` is high and `sp_ready` is low, every `sp_*` output holds its value.
- R9: Each handshake retires one sub-packet. `req_ready` rises in the cycle after the handshake of the last sub-packet.
- R10: A packet with no present destination is taken and dropped. No sub-packet appears and `req_ready` stays high.
- R11: During and directly after reset, `sp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A packet is offered by route computation |
| req_ready | output | 1 | Unit is idle and takes the offered packet |
| req_data | input | DATA_W | Payload word of the packet |
| req_addr | input | NUM_DEST*ADDR_W | Destination addresses, lane i for destination i |
| req_cand | input | NUM_DEST*7 | Candidate port masks, 7 bits per destination |
| sp_valid | output | 1 | A sub-packet is offered to the crossbar |
| sp_ready | input | 1 | Crossbar takes the sub-packet |
| sp_port | output | 7 | One-hot output port of the sub-packet |
| sp_dmask | output | NUM_DEST | Destinations carried by the sub-packet |
| sp_addr | output | NUM_DEST*ADDR_W | Addresses of carried destinations, others zero |
| sp_data | output | DATA_W | Shared payload word |

## Verification
The hardest case to reach is a packet in which several ambiguous destinations share a request. Only there does the flag advance more than once inside a single packet, and the packet may split one way for some destinations and the other way for the rest. The stimulus builds such packets directly, including one with four ambiguous destinations. It then runs a long series of packets with mixed masks, so that the flag starts a packet at either value. Backpressure covers the other awkward window: holding `sp_ready` low while a second request waits shows that the pending request is held off and the stalled sub-packet stays unchanged.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    localparam int NPORT = 7;

    typedef enum logic [2:0] {
        P_LOCAL = 3'd0,
        P_EAST  = 3'd1,
        P_WEST  = 3'd2,
        P_NORTH = 3'd3,
        P_SOUTH = 3'd4,
        P_UP    = 3'd5,
        P_DOWN  = 3'd6
    } port_e;

    localparam logic [NPORT-1:0] HORIZ_SET = (7'd1 << P_EAST)  | (7'd1 << P_WEST);
    localparam logic [NPORT-1:0] VERT_SET  = (7'd1 << P_NORTH) | (7'd1 << P_SOUTH);

    // isolates the lowest set bit; zero stays zero
    function automatic logic [NPORT-1:0] lowest_bit(input logic [NPORT-1:0] v);
        return v & (~v + 7'd1);
    endfunction
endpackage

// File: rtl/mcr_dest_resolve.sv
module mcr_dest_resolve
    import mcr_pkg::*;
(
    input  logic [NPORT-1:0] cand,
    input  logic             flag_in,
    output logic [NPORT-1:0] port_oh,
    output logic             ambig
);
    logic             has_h;
    logic             has_v;
    logic [NPORT-1:0] pick;

    always_comb begin
        has_h = |(cand & HORIZ_SET);
        has_v = |(cand & VERT_SET);
        ambig = has_h & has_v;
        if (ambig) begin
            pick = flag_in ? (cand & VERT_SET) : (cand & HORIZ_SET);
        end else begin
            pick = cand;
        end
        port_oh = lowest_bit(pick);
    end
endmodule

// File: rtl/mcr_group_build.sv
module mcr_group_build
    import mcr_pkg::*;
#(
    parameter int NUM_DEST = 4
) (
    input  logic [NUM_DEST*NPORT-1:0] port_oh_all,
    output logic [NPORT*NUM_DEST-1:0] grp,
    output logic [NPORT-1:0]          pend
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        for (genvar i = 0; i < NUM_DEST; i++) begin : g_dest
            assign grp[p*NUM_DEST + i] = port_oh_all[i*NPORT + p];
        end
        assign pend[p] = |grp[p*NUM_DEST +: NUM_DEST];
    end
endmodule

// File: rtl/mcr_port_pick.sv
module mcr_port_pick
    import mcr_pkg::*;
#(
    parameter int NUM_DEST = 4
) (
    input  logic [NPORT-1:0]          pend,
    input  logic [NPORT*NUM_DEST-1:0] grp,
    output logic [NPORT-1:0]          sel,
    output logic [NUM_DEST-1:0]       dmask
);
    always_comb begin
        sel   = lowest_bit(pend);
        dmask = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (sel[p]) begin
                dmask = dmask | grp[p*NUM_DEST +: NUM_DEST];
            end
        end
    end
endmodule

// File: rtl/mcr_split_recombine.sv
module mcr_split_recombine
    import mcr_pkg::*;
#(
    parameter int NUM_DEST = 4,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [DATA_W-1:0]          req_data,
    input  logic [NUM_DEST*ADDR_W-1:0] req_addr,
    input  logic [NUM_DEST*NPORT-1:0]  req_cand,
    output logic                       sp_valid,
    input  logic                       sp_ready,
    output logic [NPORT-1:0]           sp_port,
    output logic [NUM_DEST-1:0]        sp_dmask,
    output logic [NUM_DEST*ADDR_W-1:0] sp_addr,
    output logic [DATA_W-1:0]          sp_data
);
    localparam int ADDR_ALL = NUM_DEST * ADDR_W;
    localparam int GRP_W    = NPORT * NUM_DEST;

    typedef struct packed {
        logic                flag;
        logic [NPORT-1:0]    pend;
        logic [DATA_W-1:0]   data;
        logic [ADDR_ALL-1:0] addr;
        logic [GRP_W-1:0]    grp;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_DEST:0]         flag_chain;
    logic [NUM_DEST-1:0]       ambig;
    logic [NUM_DEST*NPORT-1:0] port_oh_all;
    logic [GRP_W-1:0]          new_grp;
    logic [NPORT-1:0]          new_pend;
    logic [NPORT-1:0]          sel;
    logic [NUM_DEST-1:0]       dmask;
    logic                      busy;
    logic                      accept;

    // settle every destination; the flag ripples through in index order
    assign flag_chain[0] = st_q.flag;
    for (genvar i = 0; i < NUM_DEST; i++) begin : g_res
        mcr_dest_resolve u_res (
            .cand    (req_cand[i*NPORT +: NPORT]),
            .flag_in (flag_chain[i]),
            .port_oh (port_oh_all[i*NPORT +: NPORT]),
            .ambig   (ambig[i])
        );
        assign flag_chain[i+1] = flag_chain[i] ^ ambig[i];
    end

    mcr_group_build #(.NUM_DEST(NUM_DEST)) u_grp (
        .port_oh_all (port_oh_all),
        .grp         (new_grp),
        .pend        (new_pend)
    );

    mcr_port_pick #(.NUM_DEST(NUM_DEST)) u_pick (
        .pend  (st_q.pend),
        .grp   (st_q.grp),
        .sel   (sel),
        .dmask (dmask)
    );

    assign busy   = |st_q.pend;
    assign accept = req_valid & ~busy;

    always_comb begin
        st_d = st_q;
        if (busy && sp_ready) begin
            st_d.pend = st_q.pend & ~sel;
        end
        if (accept) begin
            st_d.flag = flag_chain[NUM_DEST];
            st_d.pend = new_pend;
            st_d.data = req_data;
            st_d.addr = req_addr;
            st_d.grp  = new_grp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = ~busy;
    assign sp_valid  = busy;
    assign sp_port   = sel;
    assign sp_dmask  = dmask;
    assign sp_data   = st_q.data;

    for (genvar i = 0; i < NUM_DEST; i++) begin : g_lane
        assign sp_addr[i*ADDR_W +: ADDR_W] = dmask[i] ? st_q.addr[i*ADDR_W +: ADDR_W] : '0;
    end

    // R7
    port_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_valid |-> $countones(sp_port) == 1);

    // R6
    nonempty_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_valid |-> sp_dmask != '0);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_valid && !sp_ready) |=> (sp_valid && $stable(sp_port) && $stable(sp_dmask)
                                     && $stable(sp_data) && $stable(sp_addr)));

    // R7
    port_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_valid && $past(sp_valid && sp_ready)) |-> (sp_port > $past(sp_port)));

    // R5
    flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $stable(st_q.flag));

    // R10
    drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cand == '0) |=> (req_ready && !sp_valid));
endmodule

// File: tb/mcr_split_recombine_test.sv
module mcr_split_recombine_test;
    localparam int ND = 4;
    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [DW-1:0] req_data = '0;
    logic [ND*AW-1:0] req_addr = '0;
    logic [ND*7-1:0]  req_cand = '0;
    logic          sp_valid;
    logic          sp_ready = 1'b1;
    logic [6:0]    sp_port;
    logic [ND-1:0] sp_dmask;
    logic [ND*AW-1:0] sp_addr;
    logic [DW-1:0] sp_data;

    always #4 clk = ~clk;

    mcr_split_recombine #(.NUM_DEST(ND), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_data(req_data), .req_addr(req_addr), .req_cand(req_cand),
        .sp_valid(sp_valid), .sp_ready(sp_ready), .sp_port(sp_port),
        .sp_dmask(sp_dmask), .sp_addr(sp_addr), .sp_data(sp_data)
    );

    int    nchk = 0;
    int    nfail = 0;
    string tag = "R11";
    int    rmode = 0;
    int    cyc = 0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // reference model state
    logic [6:0]       qp[$];
    logic [ND-1:0]    qm[$];
    logic [DW-1:0]    qd[$];
    logic [ND*AW-1:0] qa[$];
    bit               mflag = 1'b0;

    task automatic model_accept();
        int  port_of[ND];
        bit  present[ND];
        for (int i = 0; i < ND; i++) begin
            logic [6:0] c;
            int p;
            c = req_cand[i*7 +: 7];
            present[i] = (c != 0);
            p = 0;
            if (c != 0) begin
                if ((c[1] || c[2]) && (c[3] || c[4])) begin
                    if (!mflag) p = c[1] ? 1 : 2;
                    else        p = c[3] ? 3 : 4;
                    mflag = !mflag;
                end else begin
                    for (int k = 6; k >= 0; k--) if (c[k]) p = k;
                end
            end
            port_of[i] = p;
        end
        for (int pp = 0; pp < 7; pp++) begin
            logic [ND-1:0]    m;
            logic [ND*AW-1:0] a;
            m = '0;
            a = '0;
            for (int i = 0; i < ND; i++) begin
                if (present[i] && port_of[i] == pp) begin
                    m[i] = 1'b1;
                    a[i*AW +: AW] = req_addr[i*AW +: AW];
                end
            end
            if (m != 0) begin
                qp.push_back(7'd1 << pp);
                qm.push_back(m);
                qd.push_back(req_data);
                qa.push_back(a);
            end
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            qp.delete(); qm.delete(); qd.delete(); qa.delete();
            mflag = 1'b0;
        end else begin
            bit was_busy;
            was_busy = (qp.size() > 0);
            if (was_busy && sp_ready) begin
                void'(qp.pop_front()); void'(qm.pop_front());
                void'(qd.pop_front()); void'(qa.pop_front());
            end
            if (!was_busy && req_valid) model_accept();
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit ev;
            ev = (qp.size() > 0);
            chk(sp_valid == ev, "sp_valid (R2/R9)", 64'(sp_valid), 64'(ev));
            chk(req_ready == !ev, "req_ready (R1/R9)", 64'(req_ready), 64'(!ev));
            if (ev && sp_valid) begin
                chk(sp_port == qp[0], "sp_port (R7)", 64'(sp_port), 64'(qp[0]));
                chk(sp_dmask == qm[0], "sp_dmask (R6)", 64'(sp_dmask), 64'(qm[0]));
                chk(sp_data == qd[0], "sp_data (R2)", 64'(sp_data), 64'(qd[0]));
                chk(sp_addr == qa[0], "sp_addr (R6)", 64'(sp_addr), 64'(qa[0]));
            end
        end
    end

    // crossbar readiness patterns
    always @(negedge clk) begin
        case (rmode)
            0: sp_ready <= 1'b1;
            1: sp_ready <= 1'b0;
            2: sp_ready <= cyc[0];
            default: sp_ready <= ($urandom % 3) != 0;
        endcase
    end

    localparam logic [6:0] CL = 7'h01, CE = 7'h02, CW = 7'h04, CN = 7'h08;
    localparam logic [6:0] CS = 7'h10, CU = 7'h20, CD = 7'h40;

    task automatic send(input logic [DW-1:0] d, input logic [ND*AW-1:0] a,
                        input logic [6:0] c0, input logic [6:0] c1,
                        input logic [6:0] c2, input logic [6:0] c3);
        @(negedge clk);
        req_valid = 1'b1;
        req_data  = d;
        req_addr  = a;
        req_cand  = {c3, c2, c1, c0};
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (qp.size() != 0 || !req_ready);
        @(negedge clk);
    endtask

    function automatic logic [6:0] rand_cand();
        int r;
        r = $urandom % 9;
        if (r == 0) return 7'h00;
        if (r == 8) return (($urandom % 2) ? CE : CW) | (($urandom % 2) ? CN : CS);
        return 7'd1 << (r - 1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        tag = "watchdog";
        chk(1'b0, "run did not complete", 64'(cyc), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R11: reset state
        tag = "R11";
        repeat (3) @(negedge clk);
        chk(sp_valid == 1'b0, "sp_valid in reset", 64'(sp_valid), 64'd0);
        chk(req_ready == 1'b1, "req_ready in reset", 64'(req_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp_valid == 1'b0, "sp_valid after reset", 64'(sp_valid), 64'd0);
        chk(req_ready == 1'b1, "req_ready after reset", 64'(req_ready), 64'd1);

        // R2 / R3: single destination
        tag = "R2";
        send(32'hA5A5_0001, {6'd0, 6'd0, 6'd0, 6'd11}, CL, 7'h00, 7'h00, 7'h00);
        drain();
        tag = "R3";
        send(32'h0000_0003, {6'd4, 6'd3, 6'd2, 6'd1}, CU | CD, CD, 7'h00, CE);
        drain();

        // R7: four distinct ports, given out of port order
        tag = "R7";
        send(32'h1234_5678, {6'd40, 6'd30, 6'd20, 6'd10}, CD, CN, CW, CL);
        drain();

        // R6: grouping onto shared ports
        tag = "R6";
        send(32'hCAFE_0006, {6'd63, 6'd17, 6'd9, 6'd5}, CS, CU, CS, CU);
        drain();
        send(32'hCAFE_0007, {6'd1, 6'd2, 6'd3, 6'd4}, CE, CE, CE, CE);
        drain();

        // R4: one ambiguous destination per packet, flag alternates
        tag = "R4";
        for (int k = 0; k < 4; k++) begin
            send(32'h4000_0000 + k, {6'd0, 6'd0, 6'd0, 6'(k + 1)}, CE | CN, 7'h00, 7'h00, 7'h00);
            drain();
        end
        send(32'h4000_0010, {6'd0, 6'd0, 6'd0, 6'd7}, CW | CS, 7'h00, 7'h00, 7'h00);
        drain();

        // R5: several ambiguous destinations inside one packet
        tag = "R5";
        send(32'h5000_0001, {6'd44, 6'd33, 6'd22, 6'd11}, CE | CN, CW | CS, CE | CS, CW | CN);
        drain();
        send(32'h5000_0002, {6'd4, 6'd3, 6'd2, 6'd1}, CE | CN, CL, CE | CN, CU);
        drain();

        // R10: no destination present
        tag = "R10";
        send(32'hDEAD_0010, {6'd1, 6'd2, 6'd3, 6'd4}, 7'h00, 7'h00, 7'h00, 7'h00);
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "ready after drop", 64'(req_ready), 64'd1);
        chk(sp_valid == 1'b0, "no output after drop", 64'(sp_valid), 64'd0);

        // R8: backpressure with stall
        tag = "R8";
        rmode = 1;
        send(32'h8888_0008, {6'd5, 6'd6, 6'd7, 6'd8}, CL, CN, CD, CU);
        repeat (5) @(negedge clk);
        rmode = 2;
        drain();
        rmode = 0;

        // R1: request held while busy must not disturb the packet in progress
        tag = "R1";
        rmode = 1;
        send(32'h1111_0001, {6'd12, 6'd13, 6'd14, 6'd15}, CE, CW, CN, CS);
        fork
            send(32'h2222_0002, {6'd50, 6'd51, 6'd52, 6'd53}, CL, CL, CU, CD);
            begin
                repeat (6) @(negedge clk);
                chk(req_ready == 1'b0, "ready while busy", 64'(req_ready), 64'd0);
                rmode = 0;
            end
        join
        drain();

        // R9: mixed traffic under random backpressure
        tag = "R9";
        rmode = 3;
        for (int n = 0; n < 60; n++) begin
            send($urandom, {6'($urandom), 6'($urandom), 6'($urandom), 6'($urandom)},
                 rand_cand(), rand_cand(), rand_cand(), rand_cand());
        end
        drain();
        rmode = 0;
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule